// File: doc/BRIEF.md
# Dead-Band Generator with Kill

This block turns one PWM reference into two complementary phase outputs that never overlap. `phi_hi` follows the high level of the reference and `phi_lo` follows its low level. Every reference transition drops the phase that was active. The other phase is then held low for a programmable number of clocks before it rises. A phase therefore stays high for the reference width minus the dead-band count. If the reference width is no greater than the dead band, the phase does not appear at all.

A kill input blanks both outputs at once, without waiting for a clock edge. The block does not clear the blanking when kill drops. It waits for the next rising clock to do that. A 2-bit mode input chooses what happens afterwards:
- Synchronous restart clears the block's state, and the block restarts on the next reference transition.
- Asynchronous restart keeps the block's state running underneath the kill.
- Disable latches the block off until the enable input is taken low and then high again.

Top module: `dbk_deadband_gen`

## Requirements
- R1: While `rst` is high or `enable` is low, both outputs are 0. After either one is released, both stay 0 until the first reference transition.
- R2: A transition of `pwm_ref` first sampled at clock edge k drops the active phase after edge k+1. The incoming phase rises after edge k+1+D, where D is the `db_period` value loaded at that transition.
- R3: A phase stays high for W−D clocks, where W is the width in clocks of the matching reference level.
- R4: When W ≤ D, the matching phase is never asserted. After the next transition, the opposite phase still waits the full D clocks.
- R5: With D = 0, the outputs are exact complements after the first transition, with no clock where both are low.
- R6: A change of `db_period` takes effect only at the next reference transition. A dead band that is already running keeps the value it started with.
- R7: While `kill` is 1, both outputs are 0 combinationally, in every mode.
- R8: After `kill` falls, both outputs stay 0 until the next rising clock edge.
- R9: With `kill_mode` = 00 (synchronous restart), the state is cleared while kill is active. Transitions that occur during kill are ignored. After release, the outputs stay 0 until the next transition, and that transition gets a full dead band.
- R10: With `kill_mode` = 01 (asynchronous restart), kill leaves the state untouched. After release, the outputs show whatever the state has reached by then.
- R11: With `kill_mode` = 10 or 11 (disable), a kill keeps both outputs at 0 until `enable` has been low for at least one clock and is then set high again.
- R12: `phi_hi` and `phi_lo` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable. A low level also clears a disable latch |
| pwm_ref | input | 1 | PWM reference |
| kill | input | 1 | Asynchronous output blanking |
| db_period | input | DB_W | Dead-band length in clocks |
| kill_mode | input | 2 | 00 sync restart, 01 async restart, 10/11 disable |
| phi_hi | output | 1 | Phase that follows the reference high level |
| phi_lo | output | 1 | Phase that follows the reference low level |

## Verification
The assertions check these properties on every cycle:
- the outputs never overlap;
- kill blanks the outputs;
- blanking is held through the clock after kill is released;
- a latched disable keeps the outputs low;
- the outputs are low while the dead-band count is nonzero and right after a transition;
- the outputs are cleared after a clear condition.

Only the bench scenarios can show the other behaviours:
- the measured pulse widths (W−D, a vanishing pulse when W ≤ D, and a full dead band after a vanished pulse);
- a new dead-band value waiting for the next transition;
- transitions being ignored under a synchronous-restart kill;
- state continuing under an asynchronous-restart kill;
- the enable toggle that a disable needs before output resumes.

// File: rtl/dbk_pkg.sv
package dbk_pkg;

  typedef enum logic [1:0] {
    KM_SYNC    = 2'b00,
    KM_ASYNC   = 2'b01,
    KM_DISABLE = 2'b10,
    KM_RSVD    = 2'b11
  } kill_mode_e;

endpackage

// File: rtl/dbk_edge_det.sv
module dbk_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  output logic ref_lvl,
  output logic edge_hit
);

  logic ref_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_lvl  <= 1'b0;
      ref_prev <= 1'b0;
    end else begin
      ref_lvl  <= ref_in;
      ref_prev <= ref_lvl;
    end
  end

  assign edge_hit = ref_lvl ^ ref_prev;

endmodule

// File: rtl/dbk_kill_ctrl.sv
module dbk_kill_ctrl
  import dbk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       kill,
  input  logic [1:0] kill_mode,
  output logic       gate,
  output logic       clr_state,
  output logic       disabled
);

  kill_mode_e mode;
  logic       kill_q;
  logic       kill_act;
  logic       mode_dis;

  assign mode     = kill_mode_e'(kill_mode);
  assign mode_dis = (mode == KM_DISABLE) || (mode == KM_RSVD);

  // Release of kill is held to the next rising clock
  always_ff @(posedge clk) begin
    if (rst) kill_q <= 1'b0;
    else     kill_q <= kill;
  end

  assign kill_act = kill | kill_q;

  always_ff @(posedge clk) begin
    if (rst) disabled <= 1'b0;
    else     disabled <= enable & (disabled | (kill_act & mode_dis));
  end

  assign gate      = kill_act | disabled;
  assign clr_state = ~enable | disabled | (kill_act & (mode != KM_ASYNC));

  AST_DISABLE_NEEDS_ENABLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (disabled && enable) |=> disabled); // R11

endmodule

// File: rtl/dbk_db_timer.sv
module dbk_db_timer #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            edge_hit,
  input  logic            ref_lvl,
  input  logic [DB_W-1:0] db_period,
  output logic            ph_hi,
  output logic            ph_lo
);

  localparam logic [DB_W-1:0] CNT_ZERO = '0;

  logic [DB_W-1:0] cnt;
  logic            armed;
  logic            lvl;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= CNT_ZERO;
      armed <= 1'b0;
      lvl   <= 1'b0;
      ph_hi <= 1'b0;
      ph_lo <= 1'b0;
    end else if (edge_hit) begin
      armed <= 1'b1;
      lvl   <= ref_lvl;
      if (db_period == CNT_ZERO) begin
        cnt   <= CNT_ZERO;
        ph_hi <= ref_lvl;
        ph_lo <= ~ref_lvl;
      end else begin
        cnt   <= db_period - 1'b1;
        ph_hi <= 1'b0;
        ph_lo <= 1'b0;
      end
    end else if (armed) begin
      if (cnt != CNT_ZERO) begin
        cnt   <= cnt - 1'b1;
        ph_hi <= 1'b0;
        ph_lo <= 1'b0;
      end else begin
        ph_hi <= lvl;
        ph_lo <= ~lvl;
      end
    end
  end

  AST_QUIET_DURING_COUNT: assert property (@(posedge clk) disable iff (rst)
    (cnt != CNT_ZERO) |-> (!ph_hi && !ph_lo)); // R2

  AST_EDGE_DROPS_PHASES: assert property (@(posedge clk) disable iff (rst)
    (edge_hit && !clr && db_period != CNT_ZERO) |=> (!ph_hi && !ph_lo)); // R2

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!ph_hi && !ph_lo)); // R1

endmodule

// File: rtl/dbk_deadband_gen.sv
module dbk_deadband_gen #(
  parameter int DB_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enable,
  input  logic            pwm_ref,
  input  logic            kill,
  input  logic [DB_W-1:0] db_period,
  input  logic [1:0]      kill_mode,
  output logic            phi_hi,
  output logic            phi_lo
);

  logic ref_lvl;
  logic edge_hit;
  logic gate;
  logic clr_state;
  logic disabled;
  logic ph_hi;
  logic ph_lo;

  dbk_edge_det u_edge (
    .clk      (clk),
    .rst      (rst),
    .ref_in   (pwm_ref),
    .ref_lvl  (ref_lvl),
    .edge_hit (edge_hit)
  );

  dbk_kill_ctrl u_kill (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .kill      (kill),
    .kill_mode (kill_mode),
    .gate      (gate),
    .clr_state (clr_state),
    .disabled  (disabled)
  );

  dbk_db_timer #(.DB_W(DB_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr_state),
    .edge_hit  (edge_hit),
    .ref_lvl   (ref_lvl),
    .db_period (db_period),
    .ph_hi     (ph_hi),
    .ph_lo     (ph_lo)
  );

  // Kill blanks the registered phases with no clock in the path
  assign phi_hi = ph_hi & ~gate;
  assign phi_lo = ph_lo & ~gate;

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(phi_hi && phi_lo)); // R12

  AST_KILL_BLANKS: assert property (@(posedge clk) disable iff (rst)
    kill |-> (!phi_hi && !phi_lo)); // R7

  AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!kill && $past(kill)) |-> (!phi_hi && !phi_lo)); // R8

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
    disabled |-> (!phi_hi && !phi_lo)); // R11

endmodule

// File: tb/dbk_deadband_gen_tb.sv
module dbk_deadband_gen_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       pwm_ref = 1'b0;
  logic       kill = 1'b0;
  logic [7:0] db_period = 8'd2;
  logic [1:0] kill_mode = 2'b00;
  logic       phi_hi;
  logic       phi_lo;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // pulse monitor
  int run_hi = 0, run_lo = 0, last_hi = 0, last_lo = 0, n_hi = 0, n_lo = 0, zero_cnt = 0;

  // behavioural model state
  bit m_rq = 0, m_rd = 0, m_kq = 0, m_dis = 0, m_arm = 0, m_lvl = 0;
  int m_since = 0, m_dbl = 0;

  always #4 clk = ~clk;

  dbk_deadband_gen #(.DB_W(8)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .pwm_ref(pwm_ref), .kill(kill),
    .db_period(db_period), .kill_mode(kill_mode), .phi_hi(phi_hi), .phi_lo(phi_lo)
  );

  task automatic check_bits(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {hi,lo} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_int(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: edge starts a dead band, phase is on once the
  // count of clocks since the edge reaches the period latched there.
  always @(posedge clk) begin
    bit kact, clr, ndis, edg, exp_on, g;
    if (rst) begin
      m_rq = 0; m_rd = 0; m_kq = 0; m_dis = 0; m_arm = 0; m_lvl = 0;
      m_since = 0; m_dbl = 0;
    end else begin
      kact = kill | m_kq;
      clr  = !enable || m_dis || (kact && kill_mode != 2'b01);
      ndis = enable && (m_dis || (kact && kill_mode[1]));
      edg  = (m_rq != m_rd);
      if (clr) m_arm = 0;
      else if (edg) begin
        m_arm = 1; m_lvl = m_rq; m_since = 0; m_dbl = int'(db_period);
      end else if (m_since < 100000) m_since++;
      m_kq = kill; m_dis = ndis; m_rd = m_rq; m_rq = pwm_ref;
    end
    #2;
    exp_on = m_arm && (m_since >= m_dbl);
    g = kill | m_kq | m_dis;
    check_bits(cur_req, {phi_hi, phi_lo},
               rst ? 2'b00 : {exp_on && m_lvl && !g, exp_on && !m_lvl && !g});
    if (phi_hi && phi_lo) check_bits("R12", 2'b11, 2'b00);
    if (phi_hi) run_hi++; else if (run_hi > 0) begin last_hi = run_hi; run_hi = 0; n_hi++; end
    if (phi_lo) run_lo++; else if (run_lo > 0) begin last_lo = run_lo; run_lo = 0; n_lo++; end
    if (!phi_hi && !phi_lo) zero_cnt++;
  end

  task automatic seg(logic lvl, int w);
    @(negedge clk);
    pwm_ref = lvl;
    repeat (w - 1) @(negedge clk);
  endtask

  task automatic sample_out(output logic [1:0] v);
    @(posedge clk); #2;
    v = {phi_hi, phi_lo};
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] v;
    int nl;
    repeat (3) @(negedge clk);
    sample_out(v); check_bits("R1", v, 2'b00);
    @(negedge clk); rst = 0; enable = 1;
    repeat (4) begin sample_out(v); check_bits("R1", v, 2'b00); end

    // R2/R3 basic widths, D=2
    cur_req = "R2";
    seg(1, 6); seg(0, 4); seg(1, 6); seg(0, 4); seg(1, 6);
    check_int("R3", "lo width W=4 D=2", last_lo, 2);
    check_int("R3", "hi width W=6 D=2", last_hi, 4);
    cur_req = "R3";
    seg(0, 3); seg(1, 6);
    check_int("R3", "lo width W=3 D=2", last_lo, 1);

    // R4 vanishing pulse
    cur_req = "R4";
    nl = n_lo;
    seg(0, 2); seg(1, 6);
    check_int("R4", "lo pulses W=D", n_lo, nl);
    seg(0, 5);
    check_int("R4", "hi width after vanished", last_hi, 4);
    db_period = 8'd5;
    seg(1, 6); seg(0, 3); seg(1, 8);
    check_int("R4", "lo pulses W<D", n_lo, nl + 1);

    // R5 zero dead band
    cur_req = "R5";
    db_period = 8'd0;
    seg(0, 3); seg(1, 3);
    zero_cnt = 0;
    seg(0, 3); seg(1, 3); seg(0, 3); seg(1, 3);
    check_int("R5", "both-low clocks D=0", zero_cnt, 0);
    check_int("R5", "lo width D=0", last_lo, 3);

    // R6 period change mid-interval
    cur_req = "R6";
    db_period = 8'd2;
    seg(0, 6); seg(1, 3);
    db_period = 8'd4;
    seg(1, 3); seg(0, 6); seg(1, 6);
    check_int("R6", "hi width old D", last_hi, 4);
    check_int("R6", "lo width new D", last_lo, 2);
    db_period = 8'd2;
    seg(0, 6);

    // R7/R8/R10 async restart
    cur_req = "R10";
    kill_mode = 2'b01;
    seg(1, 8);
    @(negedge clk); pwm_ref = 0; repeat (4) @(negedge clk);
    kill = 1; #1; check_bits("R7", {phi_hi, phi_lo}, 2'b00);
    repeat (2) @(negedge clk);
    kill = 0; #1; check_bits("R8", {phi_hi, phi_lo}, 2'b00);
    sample_out(v); check_bits("R10", v, 2'b01);
    repeat (3) @(negedge clk);

    // R9 sync restart
    cur_req = "R9";
    kill_mode = 2'b00;
    @(negedge clk); kill = 1; #1; check_bits("R7", {phi_hi, phi_lo}, 2'b00);
    seg(1, 3); seg(0, 3);
    @(negedge clk); kill = 0;
    repeat (4) begin sample_out(v); check_bits("R9", v, 2'b00); end
    seg(0, 1); seg(1, 6); seg(0, 4);
    check_int("R9", "hi width after restart", last_hi, 4);
    seg(1, 6);

    // R11 disable mode 10, then 11
    cur_req = "R11";
    kill_mode = 2'b10;
    @(negedge clk); kill = 1;
    @(negedge clk); kill = 0;
    seg(0, 5); seg(1, 5); seg(0, 5);
    sample_out(v); check_bits("R11", v, 2'b00);
    @(negedge clk); enable = 0;
    sample_out(v); check_bits("R1", v, 2'b00);
    @(negedge clk); enable = 1;
    seg(1, 5); seg(0, 5);
    check_int("R11", "hi width after re-enable", last_hi, 3);
    kill_mode = 2'b11;
    @(negedge clk); kill = 1;
    @(negedge clk); kill = 0;
    seg(1, 5); seg(0, 5);
    sample_out(v); check_bits("R11", v, 2'b00);
    @(negedge clk); enable = 0;
    @(negedge clk); enable = 1;
    seg(1, 5); seg(0, 5);
    check_int("R11", "hi width mode 11 re-enable", last_hi, 3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule